// File: doc/BRIEF.md
# Image Rotation Transfer Controller

This block copies an image from one region of external memory to another and transforms it on the way. It can turn the image a quarter turn clockwise, turn it a quarter turn counter-clockwise, or flip it left to right. A processor sets the job up through a small word-addressed register file: the two physical base addresses, the image dimensions and a command. It then sets the start bit and waits for the interrupt.

The controller issues every memory access itself. It reads one 32-bit source pixel at a time over a single-beat read request/response port. It writes that pixel to its computed destination position over a matching single-beat write port. It waits for each write response before it issues the next read. When every pixel has been moved, it raises a sticky interrupt, which software clears by writing to the status register.

Top module: `rot_xfer`

## Requirements
- R1: After reset the status register (offset 4) reads 0 (bit 0 busy, bit 1 done), the irq output is low, and no read or write request is asserted while the block is idle.
- R2: With command operation 0 (clockwise), source pixel (r,c) of a W-by-H image is written to destination byte address dst + 4*(c*H + H-1-r).
- R3: With command operation 1 (counter-clockwise), source pixel (r,c) is written to dst + 4*((W-1-c)*H + r).
- R4: With command operation 2 (mirror), source pixel (r,c) is written to dst + 4*(r*W + W-1-c).
- R5: Source pixels are read from src + 4*(r*W + c) in raster order, with the column index changing fastest. The data written is exactly the data returned by the read.
- R6: A request keeps its valid, address and data stable until it is accepted. No read is issued while a write is waiting for its response, so only one transaction is outstanding at any time.
- R7: irq rises only after the last write response and stays high until software writes 1 to status bit 1 or issues a new start. busy is low whenever irq is high.
- R8: Operation code 3 is reserved. Starting with it completes with irq set and no memory traffic.
- R9: A width or height of zero completes with irq set and no memory traffic.
- R10: Writes to offsets 0 to 3 while busy have no effect, and the job in flight keeps its original addresses.
- R11: The register map is: offset 0 source base, offset 1 destination base, offset 2 dimensions (width in bits 11:0, height in bits 27:16), offset 3 command (operation in bits 1:0, start in bit 4). The start bit always reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Read byte address |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | DATA_W | Read data |
| wr_req_valid | output | 1 | Write request valid |
| wr_req_ready | input | 1 | Write request accepted |
| wr_req_addr | output | ADDR_W | Write byte address |
| wr_req_data | output | DATA_W | Write data |
| wr_rsp_valid | input | 1 | Write completion |
| irq | output | 1 | Job-complete interrupt, sticky |

## Verification
The bench uses the default parameters: 32-bit addresses and pixels and 12-bit dimensions. Small images of one pixel, one row, one column, square and non-square shapes then reach the wrap of the column counter and the last-row cases of all three transforms within a few hundred cycles. The memory model handshakes with a pseudo-random ready pattern. Every accepted request is compared against queues built from the mapping equations, which exposes stall and ordering faults as well as address faults.

// File: rtl/rot_pkg.sv
package rot_pkg;
    typedef enum logic [1:0] {
        OP_CW  = 2'd0,
        OP_CCW = 2'd1,
        OP_MIR = 2'd2,
        OP_RSV = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_WR_RESP,
        ST_DONE
    } state_e;

    localparam logic [2:0] REG_SRC  = 3'd0;
    localparam logic [2:0] REG_DST  = 3'd1;
    localparam logic [2:0] REG_DIM  = 3'd2;
    localparam logic [2:0] REG_CMD  = 3'd3;
    localparam logic [2:0] REG_STAT = 3'd4;

    localparam int HEIGHT_LSB = 16;
    localparam int START_BIT  = 4;
    localparam int DONE_BIT   = 1;
endpackage

// File: rtl/rot_regs.sv
module rot_regs
    import rot_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DIM_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              busy,
    input  logic              fin,
    output logic              start,
    output op_e               op_next,
    output logic [ADDR_W-1:0] src_base,
    output logic [ADDR_W-1:0] dst_base,
    output logic [DIM_W-1:0]  width,
    output logic [DIM_W-1:0]  height,
    output logic              irq
);
    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [DIM_W-1:0]  w;
        logic [DIM_W-1:0]  h;
        op_e               op;
        logic              done;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d   = r_q;
        start = 1'b0;
        if (fin) r_d.done = 1'b1;
        if (cfg_we) begin
            case (cfg_addr)
                REG_SRC: if (!busy) r_d.src = cfg_wdata[ADDR_W-1:0];
                REG_DST: if (!busy) r_d.dst = cfg_wdata[ADDR_W-1:0];
                REG_DIM: if (!busy) begin
                    r_d.w = cfg_wdata[DIM_W-1:0];
                    r_d.h = cfg_wdata[HEIGHT_LSB +: DIM_W];
                end
                REG_CMD: if (!busy) begin
                    r_d.op = op_e'(cfg_wdata[1:0]);
                    if (cfg_wdata[START_BIT]) begin
                        start     = 1'b1;
                        r_d.done  = 1'b0;
                    end
                end
                REG_STAT: if (cfg_wdata[DONE_BIT]) r_d.done = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            REG_SRC:  cfg_rdata = 32'(r_q.src);
            REG_DST:  cfg_rdata = 32'(r_q.dst);
            REG_DIM:  begin
                cfg_rdata[DIM_W-1:0]              = r_q.w;
                cfg_rdata[HEIGHT_LSB +: DIM_W]    = r_q.h;
            end
            REG_CMD:  cfg_rdata[1:0] = r_q.op;
            REG_STAT: cfg_rdata[1:0] = {r_q.done, busy};
            default:  cfg_rdata = '0;
        endcase
    end

    assign op_next  = r_d.op;
    assign src_base = r_q.src;
    assign dst_base = r_q.dst;
    assign width    = r_q.w;
    assign height   = r_q.h;
    assign irq      = r_q.done;
endmodule

// File: rtl/rot_addr.sv
module rot_addr
    import rot_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DIM_W  = 12
) (
    input  op_e               op,
    input  logic [DIM_W-1:0]  row,
    input  logic [DIM_W-1:0]  col,
    input  logic [DIM_W-1:0]  width,
    input  logic [DIM_W-1:0]  height,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] wr_addr
);
    localparam int IDX_W  = 2 * DIM_W;
    localparam int PIX_SH = $clog2(DATA_W / 8);

    logic [IDX_W-1:0] r_x, c_x, w_x, h_x;
    logic [IDX_W-1:0] s_idx, d_idx;

    always_comb begin
        r_x   = IDX_W'(row);
        c_x   = IDX_W'(col);
        w_x   = IDX_W'(width);
        h_x   = IDX_W'(height);
        s_idx = r_x * w_x + c_x;
        case (op)
            OP_CW:   d_idx = c_x * h_x + (h_x - 1'b1 - r_x);
            OP_CCW:  d_idx = (w_x - 1'b1 - c_x) * h_x + r_x;
            default: d_idx = r_x * w_x + (w_x - 1'b1 - c_x);
        endcase
    end

    generate
        if (PIX_SH == 0) begin : g_byte_pix
            assign rd_addr = src_base + ADDR_W'(s_idx);
            assign wr_addr = dst_base + ADDR_W'(d_idx);
        end else begin : g_wide_pix
            assign rd_addr = src_base + (ADDR_W'(s_idx) << PIX_SH);
            assign wr_addr = dst_base + (ADDR_W'(d_idx) << PIX_SH);
        end
    endgenerate
endmodule

// File: rtl/rot_seq.sv
module rot_seq
    import rot_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DIM_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  op_e               op_next,
    input  logic [DIM_W-1:0]  width,
    input  logic [DIM_W-1:0]  height,
    input  logic              rd_req_ready,
    input  logic              rd_rsp_valid,
    input  logic [DATA_W-1:0] rd_rsp_data,
    input  logic              wr_req_ready,
    input  logic              wr_rsp_valid,
    output logic              rd_req_valid,
    output logic              wr_req_valid,
    output logic [DATA_W-1:0] pix,
    output op_e               op,
    output logic [DIM_W-1:0]  row,
    output logic [DIM_W-1:0]  col,
    output logic              busy,
    output logic              fin
);
    typedef struct packed {
        state_e            st;
        op_e               op;
        logic [DIM_W-1:0]  row;
        logic [DIM_W-1:0]  col;
        logic [DATA_W-1:0] pix;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: if (start) begin
                s_d.op  = op_next;
                s_d.row = '0;
                s_d.col = '0;
                if (op_next == OP_RSV || width == '0 || height == '0)
                    s_d.st = ST_DONE;
                else
                    s_d.st = ST_RD_REQ;
            end
            ST_RD_REQ:  if (rd_req_ready) s_d.st = ST_RD_WAIT;
            ST_RD_WAIT: if (rd_rsp_valid) begin
                s_d.pix = rd_rsp_data;
                s_d.st  = ST_WR_REQ;
            end
            ST_WR_REQ:  if (wr_req_ready) s_d.st = ST_WR_RESP;
            ST_WR_RESP: if (wr_rsp_valid) begin
                if (s_q.col == width - 1'b1) begin
                    s_d.col = '0;
                    if (s_q.row == height - 1'b1) begin
                        s_d.st = ST_DONE;
                    end else begin
                        s_d.row = s_q.row + 1'b1;
                        s_d.st  = ST_RD_REQ;
                    end
                end else begin
                    s_d.col = s_q.col + 1'b1;
                    s_d.st  = ST_RD_REQ;
                end
            end
            ST_DONE: s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, op: OP_CW, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_req_valid = (s_q.st == ST_RD_REQ);
    assign wr_req_valid = (s_q.st == ST_WR_REQ);
    assign pix          = s_q.pix;
    assign op           = s_q.op;
    assign row          = s_q.row;
    assign col          = s_q.col;
    assign busy         = (s_q.st != ST_IDLE);
    assign fin          = (s_q.st == ST_DONE);
endmodule

// File: rtl/rot_xfer.sv
module rot_xfer
    import rot_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DIM_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    input  logic              rd_rsp_valid,
    input  logic [DATA_W-1:0] rd_rsp_data,
    output logic              wr_req_valid,
    input  logic              wr_req_ready,
    output logic [ADDR_W-1:0] wr_req_addr,
    output logic [DATA_W-1:0] wr_req_data,
    input  logic              wr_rsp_valid,
    output logic              irq
);
    logic              busy, fin, start;
    op_e               op_next, op_job;
    logic [ADDR_W-1:0] src_base, dst_base;
    logic [DIM_W-1:0]  width, height, row, col;

    rot_regs #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy), .fin(fin),
        .start(start), .op_next(op_next), .src_base(src_base),
        .dst_base(dst_base), .width(width), .height(height), .irq(irq)
    );

    rot_seq #(.DATA_W(DATA_W), .DIM_W(DIM_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op_next(op_next),
        .width(width), .height(height), .rd_req_ready(rd_req_ready),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .wr_req_ready(wr_req_ready), .wr_rsp_valid(wr_rsp_valid),
        .rd_req_valid(rd_req_valid), .wr_req_valid(wr_req_valid),
        .pix(wr_req_data), .op(op_job), .row(row), .col(col),
        .busy(busy), .fin(fin)
    );

    rot_addr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIM_W(DIM_W)) u_addr (
        .op(op_job), .row(row), .col(col), .width(width), .height(height),
        .src_base(src_base), .dst_base(dst_base),
        .rd_addr(rd_req_addr), .wr_addr(wr_req_addr)
    );
endmodule

// File: rtl/rot_xfer_chk.sv
module rot_xfer_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [2:0]        cfg_addr,
    input logic [31:0]       cfg_wdata,
    input logic              rd_req_valid,
    input logic              rd_req_ready,
    input logic [ADDR_W-1:0] rd_req_addr,
    input logic              wr_req_valid,
    input logic              wr_req_ready,
    input logic [ADDR_W-1:0] wr_req_addr,
    input logic [DATA_W-1:0] wr_req_data,
    input logic              wr_rsp_valid,
    input logic              irq,
    input logic              busy
);
    logic wr_pend;
    logic clr_wr, start_wr;

    assign clr_wr   = cfg_we && cfg_addr == 3'd4 && cfg_wdata[1];
    assign start_wr = cfg_we && cfg_addr == 3'd3 && cfg_wdata[4];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_pend <= 1'b0;
        else if (wr_req_valid && wr_req_ready) wr_pend <= 1'b1;
        else if (wr_rsp_valid) wr_pend <= 1'b0;
    end

    // R1: no traffic while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_req_valid && !wr_req_valid));

    // R6: read request held stable until accepted
    p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

    // R6: write request held stable until accepted
    p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_valid && !wr_req_ready) |=>
            (wr_req_valid && $stable(wr_req_addr) && $stable(wr_req_data)));

    // R6: single outstanding transaction
    p_one_txn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pend |-> !rd_req_valid);

    // R7: interrupt only when finished
    p_irq_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy);

    // R7: interrupt is sticky
    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr && !start_wr) |=> irq);
endmodule

bind rot_xfer rot_xfer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready),
    .wr_req_addr(wr_req_addr), .wr_req_data(wr_req_data),
    .wr_rsp_valid(wr_rsp_valid), .irq(irq), .busy(busy)
);

// File: tb/rot_xfer_bench.sv
module rot_xfer_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] SB = 32'h0000_0100;
    localparam logic [31:0] DB = 32'h0000_2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        rd_req_valid, rd_req_ready, rd_rsp_valid;
    logic [31:0] rd_req_addr, rd_rsp_data;
    logic        wr_req_valid, wr_req_ready, wr_rsp_valid;
    logic [31:0] wr_req_addr, wr_req_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int traffic = 0;
    string cur_tag = "R1";

    logic [31:0] mem [0:4095];
    logic [31:0] exp_rd_q[$];
    logic [31:0] exp_wa_q[$];
    logic [31:0] exp_wd_q[$];
    logic [7:0]  lfsr = 8'h5A;

    always #(CLK_PERIOD/2) clk = ~clk;

    rot_xfer u_rot_xfer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
        .rd_rsp_data(rd_rsp_data), .wr_req_valid(wr_req_valid),
        .wr_req_ready(wr_req_ready), .wr_req_addr(wr_req_addr),
        .wr_req_data(wr_req_data), .wr_rsp_valid(wr_rsp_valid), .irq(irq)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // memory model with pseudo-random readiness, one cycle response latency
    always @(posedge clk) begin
        cycles <= cycles + 1;
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        rd_req_ready <= lfsr[0] | lfsr[3];
        wr_req_ready <= lfsr[1] | lfsr[6];
        rd_rsp_valid <= 1'b0;
        wr_rsp_valid <= 1'b0;
        if (rst_n && rd_req_valid && rd_req_ready) begin
            traffic <= traffic + 1;
            rd_rsp_data  <= mem[rd_req_addr[13:2]];
            rd_rsp_valid <= 1'b1;
            checks++;
            if (exp_rd_q.size() == 0) begin
                errors++;
                $display("FAIL %s: unexpected read actual %h expected none", cur_tag, rd_req_addr);
            end else begin
                if (rd_req_addr !== exp_rd_q[0]) begin
                    errors++;
                    $display("FAIL R5 read order: actual %h expected %h", rd_req_addr, exp_rd_q[0]);
                end
                void'(exp_rd_q.pop_front());
            end
        end
        if (rst_n && wr_req_valid && wr_req_ready) begin
            traffic <= traffic + 1;
            mem[wr_req_addr[13:2]] <= wr_req_data;
            wr_rsp_valid <= 1'b1;
            checks++;
            if (exp_wa_q.size() == 0) begin
                errors++;
                $display("FAIL %s: unexpected write actual %h expected none", cur_tag, wr_req_addr);
            end else begin
                if (wr_req_addr !== exp_wa_q[0] || wr_req_data !== exp_wd_q[0]) begin
                    errors++;
                    $display("FAIL %s write: actual %h/%h expected %h/%h", cur_tag,
                             wr_req_addr, wr_req_data, exp_wa_q[0], exp_wd_q[0]);
                end
                void'(exp_wa_q.pop_front());
                void'(exp_wd_q.pop_front());
            end
        end
    end

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic wait_irq(input int limit);
        for (int i = 0; i < limit && !irq; i++) @(negedge clk);
    endtask

    function automatic int dst_index(input int op, input int r, input int c,
                                     input int w, input int h);
        if (op == 0) return c * h + (h - 1 - r);
        if (op == 1) return (w - 1 - c) * h + r;
        return r * w + (w - 1 - c);
    endfunction

    task automatic setup(input int op, input int w, input int h, input string tag);
        cur_tag = tag;
        for (int i = 0; i < 1024; i++) mem[(SB >> 2) + i] = 32'hC0DE_0000 + i * 7 + op;
        for (int i = 0; i < 1024; i++) mem[(DB >> 2) + i] = 32'hDEAD_BEEF;
        cfg_write(3'd0, SB);
        cfg_write(3'd1, DB);
        cfg_write(3'd2, (h << 16) | w);
        if (op != 3) begin
            for (int r = 0; r < h; r++)
                for (int c = 0; c < w; c++) begin
                    exp_rd_q.push_back(SB + 4 * (r * w + c));
                    exp_wa_q.push_back(DB + 4 * dst_index(op, r, c, w, h));
                    exp_wd_q.push_back(mem[(SB >> 2) + r * w + c]);
                end
        end
    endtask

    task automatic finish_job(input int op, input int w, input int h, input string tag);
        logic [31:0] v;
        bit ok;
        wait_irq(20000);
        check(irq === 1'b1, {tag, " irq after job"}, irq, 1);
        check(exp_wa_q.size() == 0 && exp_rd_q.size() == 0, {tag, " all pixels moved"},
              exp_wa_q.size(), 0);
        cfg_read(3'd4, v);
        check(v[1:0] == 2'b10, "R7 status done not busy", v, 2);
        ok = 1'b1;
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++)
                if (mem[(DB >> 2) + dst_index(op, r, c, w, h)] !== mem[(SB >> 2) + r * w + c])
                    ok = 1'b0;
        check(ok, {tag, " destination image"}, ok, 1);
        repeat (3) @(negedge clk);
        check(irq === 1'b1, "R7 irq stays high", irq, 1);
        cfg_write(3'd4, 32'h2);
        check(irq === 1'b0, "R7 irq cleared by status write", irq, 0);
    endtask

    task automatic run(input int op, input int w, input int h, input string tag);
        setup(op, w, h, tag);
        cfg_write(3'd3, 32'h10 | op);
        finish_job(op, w, h, tag);
    endtask

    task automatic run_empty(input int op, input int w, input int h, input string tag);
        int t0;
        setup(op, w, h, tag);
        t0 = traffic;
        cfg_write(3'd3, 32'h10 | op);
        wait_irq(10);
        check(irq === 1'b1, {tag, " immediate completion"}, irq, 1);
        check(traffic == t0, {tag, " no memory traffic"}, traffic - t0, 0);
        cfg_write(3'd4, 32'h2);
    endtask

    initial begin
        logic [31:0] v;
        int t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cfg_read(3'd4, v);
        check(v == 32'h0, "R1 status after reset", v, 0);
        check(irq === 1'b0 && !rd_req_valid && !wr_req_valid, "R1 outputs after reset",
              {irq, rd_req_valid, wr_req_valid}, 0);

        run(0, 5, 3, "R2");
        run(0, 1, 1, "R2");
        run(1, 4, 7, "R3");
        run(1, 7, 1, "R3");
        run(2, 6, 2, "R4");
        run(2, 1, 5, "R4");

        // R10 and R11: busy job with writes that must be ignored
        setup(0, 8, 6, "R10");
        cfg_write(3'd3, 32'h10);
        cfg_read(3'd3, v);
        check(v[4] == 1'b0 && v[1:0] == 2'b00, "R11 start reads back 0", v, 0);
        cfg_read(3'd4, v);
        check(v[0] == 1'b1, "R10 busy during job", v, 1);
        cfg_write(3'd0, 32'h0000_0800);
        cfg_write(3'd2, 32'h0001_0001);
        cfg_write(3'd3, 32'h12);
        cfg_read(3'd0, v);
        check(v == SB, "R10 source base unchanged while busy", v, SB);
        cfg_read(3'd2, v);
        check(v == ((32'd6 << 16) | 32'd8), "R10 dims unchanged while busy", v, (6 << 16) | 8);
        finish_job(0, 8, 6, "R10");

        // R7: a new start also drops a pending interrupt
        run_empty(3, 4, 4, "R8");
        run_empty(0, 0, 5, "R9");
        run_empty(2, 5, 0, "R9");

        setup(1, 2, 2, "R3");
        cfg_write(3'd3, 32'h11);
        wait_irq(2000);
        cfg_write(3'd3, 32'h13);
        wait_irq(10);
        cfg_write(3'd4, 32'h2);
        t0 = traffic;
        repeat (5) @(negedge clk);
        check(traffic == t0 && irq === 1'b0, "R1 idle stays quiet", traffic - t0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule